// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. It runs entirely on the test clock. A host moves it through the sixteen-state test access port graph by driving a mode-select line that is sampled on each rising clock edge. Two branches of that graph matter. The instruction branch loads a 3-bit instruction through a serial shift register and latches it into a parallel register. The data branch shifts through whichever data register the current instruction selects.

Only the bypass data register lives inside the block. It is a single stage that gives every data scan a one-bit path from the serial input to the serial output while the bypass instruction is active. For any other instruction, the capture, shift and update strobes go out to data registers that sit outside the block.

The serial output changes on the falling clock edge. It is enabled only while a shift state is active, and it reads 0 at all other times.

Top module: `tap_ctrl`

## Requirements
- R1: The state register advances only on a rising `tck` edge, and the next state depends only on the current state and `tms`, following the standard 16-state graph. `tap_state` uses these codes: reset 4'hF, idle 4'hC, select-DR 4'h7, capture-DR 4'h6, shift-DR 4'h2, exit1-DR 4'h1, pause-DR 4'h3, exit2-DR 4'h0, update-DR 4'h5, select-IR 4'h4, capture-IR 4'hE, shift-IR 4'hA, exit1-IR 4'h9, pause-IR 4'hB, exit2-IR 4'h8, update-IR 4'hD.
- R2: When `rst_n` is low at a rising edge, the state becomes reset (4'hF). When `rst_n` is low at a falling edge, `ir_value` becomes the bypass code 3'b011, and `tdo` and `tdo_en` become 0.
- R3: From any state, five consecutive rising edges with `tms` high bring the controller to reset (4'hF). It then stays in reset for as long as `tms` stays high.
- R4: One low sample of `tms` in reset moves the controller to idle (4'hC). Three further rising edges with `tms` high then return it to reset.
- R5: A rising edge in capture-IR loads 3'b001 into the instruction shift register.
- R6: Each rising edge in shift-IR moves `tdi` into bit 2 of the instruction shift register and shifts the other bits one place toward bit 0. Bit 0 is presented on `tdo`, so the least significant bit leaves first.
- R7: On a falling edge in update-IR, `ir_value` takes the contents of the shift register. On a falling edge in reset, `ir_value` becomes 3'b011. In every other state it keeps its value.
- R8: `tdo` and `tdo_en` change only on the falling edge. `tdo_en` is 1 exactly while the state is shift-IR or shift-DR, and `tdo` is 0 whenever `tdo_en` is 0.
- R9: `bypass_sel` is 1 exactly when `ir_value` is 3'b011. With bypass selected, a rising edge in capture-DR clears the bypass stage, a rising edge in shift-DR loads `tdi` into it, and `tdo` shows the stage in shift-DR. With bypass not selected, `tdo` is 0 in shift-DR.
- R10: `dr_capture`, `dr_shift` and `dr_update` are each 1 exactly in capture-DR, shift-DR and update-DR respectively, and at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Active-low reset, sampled on both clock edges |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | Output enable for `tdo`, high only in the shift states |
| tap_state | output | 4 | Current controller state code |
| ir_value | output | 3 | Parallel instruction register |
| bypass_sel | output | 1 | High when the bypass instruction is active |
| dr_capture | output | 1 | High in capture-DR |
| dr_shift | output | 1 | High in shift-DR |
| dr_update | output | 1 | High in update-DR |

## Verification
The bench goes after four failure modes.

Recovery from random states checks that five high `tms` samples always land in reset. A slip in one branch of the next-state decode would instead leave the controller stuck in a pause or exit state. The spurious-low case checks that the path back from idle takes three edges and not two or four.

The instruction scans check two things. The captured 3'b001 must come out of `tdo` as 1, 0, 0. A design that shifted in the wrong direction would present 0 first. The new instruction must appear only after the falling edge in update-IR, and a rising-edge latch would show it half a cycle early.

The bypass scans check that `tdo` lags `tdi` by exactly one shift and starts with the captured 0. They also check that a non-bypass instruction silences the serial output.

// File: rtl/tap_pkg.sv
// Package: shared state type and constants for the test access port controller.
// Assumes the codes below match the standard boundary-scan state assignment.
package tap_pkg;

    typedef enum logic [3:0] {
        ST_EXIT2_DR   = 4'h0,
        ST_EXIT1_DR   = 4'h1,
        ST_SHIFT_DR   = 4'h2,
        ST_PAUSE_DR   = 4'h3,
        ST_SELECT_IR  = 4'h4,
        ST_UPDATE_DR  = 4'h5,
        ST_CAPTURE_DR = 4'h6,
        ST_SELECT_DR  = 4'h7,
        ST_EXIT2_IR   = 4'h8,
        ST_EXIT1_IR   = 4'h9,
        ST_SHIFT_IR   = 4'hA,
        ST_PAUSE_IR   = 4'hB,
        ST_IDLE       = 4'hC,
        ST_UPDATE_IR  = 4'hD,
        ST_CAPTURE_IR = 4'hE,
        ST_RESET      = 4'hF
    } tap_state_t;

    localparam int unsigned TAP_IR_W      = 3;
    localparam logic [TAP_IR_W-1:0] TAP_IR_CAPTURE = 3'b001;
    localparam logic [TAP_IR_W-1:0] TAP_IR_BYPASS  = 3'b011;

endpackage

// File: rtl/tap_fsm.sv
// Module: tap_fsm
// Holds the 16-state controller and advances it on each rising tck edge from tms.
// Assumes rst_n is synchronous to tck and active low.
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state_q
);

    tap_state_t state_d;

    // Next-state selection: each state has one successor for tms=0 and one for tms=1.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:      state_d = tms ? ST_RESET     : ST_IDLE;
            ST_IDLE:       state_d = tms ? ST_SELECT_DR : ST_IDLE;
            ST_SELECT_DR:  state_d = tms ? ST_SELECT_IR : ST_CAPTURE_DR;
            ST_CAPTURE_DR: state_d = tms ? ST_EXIT1_DR  : ST_SHIFT_DR;
            ST_SHIFT_DR:   state_d = tms ? ST_EXIT1_DR  : ST_SHIFT_DR;
            ST_EXIT1_DR:   state_d = tms ? ST_UPDATE_DR : ST_PAUSE_DR;
            ST_PAUSE_DR:   state_d = tms ? ST_EXIT2_DR  : ST_PAUSE_DR;
            ST_EXIT2_DR:   state_d = tms ? ST_UPDATE_DR : ST_SHIFT_DR;
            ST_UPDATE_DR:  state_d = tms ? ST_SELECT_DR : ST_IDLE;
            ST_SELECT_IR:  state_d = tms ? ST_RESET     : ST_CAPTURE_IR;
            ST_CAPTURE_IR: state_d = tms ? ST_EXIT1_IR  : ST_SHIFT_IR;
            ST_SHIFT_IR:   state_d = tms ? ST_EXIT1_IR  : ST_SHIFT_IR;
            ST_EXIT1_IR:   state_d = tms ? ST_UPDATE_IR : ST_PAUSE_IR;
            ST_PAUSE_IR:   state_d = tms ? ST_EXIT2_IR  : ST_PAUSE_IR;
            ST_EXIT2_IR:   state_d = tms ? ST_UPDATE_IR : ST_SHIFT_IR;
            ST_UPDATE_IR:  state_d = tms ? ST_SELECT_DR : ST_IDLE;
            default:       state_d = ST_RESET;
        endcase
    end

    // State register: reset forces the reset state, otherwise take the decoded successor.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/tap_ir.sv
// Module: tap_ir
// Instruction path: a serial shift register loaded with a fixed pattern on capture,
// shifted toward bit 0 on rising edges, and a parallel copy updated on falling edges.
// Assumes the enables are one-hot decodes of the controller state.
module tap_ir #(
    parameter int unsigned         IR_W       = 3,
    parameter logic [IR_W-1:0]     CAPTURE_PAT = 3'b001,
    parameter logic [IR_W-1:0]     RESET_CODE  = 3'b011
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  logic            capture_en,
    input  logic            shift_en,
    input  logic            update_en,
    input  logic            reset_en,
    output logic [IR_W-1:0] shift_q,
    output logic [IR_W-1:0] par_q
);

    localparam int unsigned MSB = IR_W - 1;

    logic [IR_W-1:0] shifted;

    // Shift network: the top bit takes tdi, every other bit takes its upper neighbour.
    for (genvar i = 0; i < IR_W; i++) begin : g_shift
        if (i == MSB) begin : g_top
            assign shifted[i] = tdi;
        end else begin : g_mid
            assign shifted[i] = shift_q[i+1];
        end
    end

    // Serial register: capture the fixed pattern or shift, on the rising edge.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            shift_q <= CAPTURE_PAT;
        end else if (capture_en) begin
            shift_q <= CAPTURE_PAT;
        end else if (shift_en) begin
            shift_q <= shifted;
        end
    end

    // Parallel register: load the bypass code in reset, copy the shift register in update.
    always_ff @(negedge tck) begin
        if (!rst_n || reset_en) begin
            par_q <= RESET_CODE;
        end else if (update_en) begin
            par_q <= shift_q;
        end
    end

endmodule

// File: rtl/tap_bypass.sv
// Module: tap_bypass
// Single-stage bypass data register: cleared in capture, loaded from tdi in shift.
// Assumes the enables are already qualified by the bypass instruction.
module tap_bypass (
    input  logic tck,
    input  logic rst_n,
    input  logic tdi,
    input  logic capture_en,
    input  logic shift_en,
    output logic byp_q
);

    // Bypass stage: zero on capture, tdi on shift, hold otherwise.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            byp_q <= 1'b0;
        end else if (capture_en) begin
            byp_q <= 1'b0;
        end else if (shift_en) begin
            byp_q <= tdi;
        end
    end

endmodule

// File: rtl/tap_ctrl.sv
// Module: tap_ctrl (top)
// Test access port controller: state machine, 3-bit instruction register, bypass
// register and a falling-edge serial output with an enable.
// Assumes a single tck domain. rst_n is active low and sampled on both edges.
module tap_ctrl
    import tap_pkg::*;
(
    input  logic                tck,
    input  logic                rst_n,
    input  logic                tms,
    input  logic                tdi,
    output logic                tdo,
    output logic                tdo_en,
    output logic [3:0]          tap_state,
    output logic [TAP_IR_W-1:0] ir_value,
    output logic                bypass_sel,
    output logic                dr_capture,
    output logic                dr_shift,
    output logic                dr_update
);

    tap_state_t          state_q;
    logic [TAP_IR_W-1:0] ir_shift_q;
    logic [TAP_IR_W-1:0] ir_par_q;
    logic                byp_q;
    logic                in_shift_ir;
    logic                tdo_d;
    logic                tdo_en_d;

    tap_fsm u_fsm (
        .tck     (tck),
        .rst_n   (rst_n),
        .tms     (tms),
        .state_q (state_q)
    );

    // State decodes used by the instruction path, the bypass stage and the strobes.
    always_comb begin
        in_shift_ir = (state_q == ST_SHIFT_IR);
        dr_capture  = (state_q == ST_CAPTURE_DR);
        dr_shift    = (state_q == ST_SHIFT_DR);
        dr_update   = (state_q == ST_UPDATE_DR);
    end

    tap_ir #(
        .IR_W        (TAP_IR_W),
        .CAPTURE_PAT (TAP_IR_CAPTURE),
        .RESET_CODE  (TAP_IR_BYPASS)
    ) u_ir (
        .tck        (tck),
        .rst_n      (rst_n),
        .tdi        (tdi),
        .capture_en (state_q == ST_CAPTURE_IR),
        .shift_en   (in_shift_ir),
        .update_en  (state_q == ST_UPDATE_IR),
        .reset_en   (state_q == ST_RESET),
        .shift_q    (ir_shift_q),
        .par_q      (ir_par_q)
    );

    assign bypass_sel = (ir_par_q == TAP_IR_BYPASS);

    tap_bypass u_byp (
        .tck        (tck),
        .rst_n      (rst_n),
        .tdi        (tdi),
        .capture_en (dr_capture && bypass_sel),
        .shift_en   (dr_shift && bypass_sel),
        .byp_q      (byp_q)
    );

    // Output source: instruction LSB in shift-IR, bypass stage in shift-DR, else 0.
    always_comb begin
        tdo_d    = 1'b0;
        tdo_en_d = 1'b0;
        if (in_shift_ir) begin
            tdo_d    = ir_shift_q[0];
            tdo_en_d = 1'b1;
        end else if (dr_shift) begin
            tdo_d    = bypass_sel ? byp_q : 1'b0;
            tdo_en_d = 1'b1;
        end
    end

    // Output register: retime serial data and its enable to the falling edge.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= tdo_d;
            tdo_en <= tdo_en_d;
        end
    end

    assign tap_state = state_q;
    assign ir_value  = ir_par_q;

endmodule

// File: rtl/tap_ctrl_chk.sv
// Module: tap_ctrl_chk
// Property checker for tap_ctrl, attached to every instance through bind.
module tap_ctrl_chk
    import tap_pkg::*;
(
    input logic       tck,
    input logic       rst_n,
    input logic       tms,
    input logic       tdi,
    input logic       tdo,
    input logic       tdo_en,
    input logic [3:0] tap_state,
    input logic [2:0] ir_value,
    input logic [2:0] ir_shift_q,
    input logic       byp_q,
    input logic       bypass_sel,
    input logic       dr_capture,
    input logic       dr_shift,
    input logic       dr_update
);

    // R3: reset is held while tms stays high
    p_hold_reset_r3: assert property (@(posedge tck) disable iff (!rst_n)
        (tap_state == ST_RESET && tms) |=> tap_state == ST_RESET);

    // R5: capture-IR loads the fixed pattern
    p_capture_ir_r5: assert property (@(posedge tck) disable iff (!rst_n)
        (tap_state == ST_CAPTURE_IR) |=> ir_shift_q == TAP_IR_CAPTURE);

    // R6: shift-IR moves tdi into the top bit and shifts the rest toward bit 0
    p_shift_ir_r6: assert property (@(posedge tck) disable iff (!rst_n)
        (tap_state == ST_SHIFT_IR) |=> ir_shift_q == {$past(tdi), $past(ir_shift_q[2:1])});

    // R7: the parallel instruction is stable unless the previous falling edge saw update or reset
    p_ir_hold_r7: assert property (@(negedge tck) disable iff (!rst_n)
        ($past(tap_state) != ST_UPDATE_IR && $past(tap_state) != ST_RESET) |-> $stable(ir_value));

    // R8: the enable seen at a rising edge matches the state the previous falling edge saw
    p_tdo_en_r8: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_en == (tap_state == ST_SHIFT_IR || tap_state == ST_SHIFT_DR));

    // R8: disabled output reads 0
    p_tdo_idle_r8: assert property (@(posedge tck) disable iff (!rst_n)
        !tdo_en |-> !tdo);

    // R9: bypass capture clears the stage
    p_byp_capture_r9: assert property (@(posedge tck) disable iff (!rst_n)
        (dr_capture && bypass_sel) |=> !byp_q);

    // R10: data register strobes are mutually exclusive
    p_strobe_excl_r10: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0({dr_capture, dr_shift, dr_update}));

endmodule

bind tap_ctrl tap_ctrl_chk u_chk (
    .tck        (tck),
    .rst_n      (rst_n),
    .tms        (tms),
    .tdi        (tdi),
    .tdo        (tdo),
    .tdo_en     (tdo_en),
    .tap_state  (tap_state),
    .ir_value   (ir_value),
    .ir_shift_q (ir_shift_q),
    .byp_q      (byp_q),
    .bypass_sel (bypass_sel),
    .dr_capture (dr_capture),
    .dr_shift   (dr_shift),
    .dr_update  (dr_update)
);

// File: tb/test_tap_ctrl.sv
// Bench for tap_ctrl: a reference model built from the requirements, directed
// corner cases and seeded random tms/tdi streams.
module test_tap_ctrl;

    localparam int PERIOD = 10;

    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic       tdo, tdo_en, bypass_sel, dr_capture, dr_shift, dr_update;
    logic [3:0] tap_state;
    logic [2:0] ir_value;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [3:0] m_state = 4'hF;
    logic [2:0] m_sr = 3'b001;
    logic [2:0] m_ir = 3'b011;
    logic       m_byp = 1'b0;
    logic       m_tdo = 1'b0;
    logic       m_en = 1'b0;

    tap_ctrl i_tap_ctrl (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .tap_state(tap_state), .ir_value(ir_value), .bypass_sel(bypass_sel),
        .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update)
    );

    always #(PERIOD/2) tck = ~tck;

    function automatic logic [3:0] nxt(input logic [3:0] s, input logic t);
        case (s)
            4'hF: return t ? 4'hF : 4'hC;
            4'hC: return t ? 4'h7 : 4'hC;
            4'h7: return t ? 4'h4 : 4'h6;
            4'h6: return t ? 4'h1 : 4'h2;
            4'h2: return t ? 4'h1 : 4'h2;
            4'h1: return t ? 4'h5 : 4'h3;
            4'h3: return t ? 4'h0 : 4'h3;
            4'h0: return t ? 4'h5 : 4'h2;
            4'h5: return t ? 4'h7 : 4'hC;
            4'h4: return t ? 4'hF : 4'hE;
            4'hE: return t ? 4'h9 : 4'hA;
            4'hA: return t ? 4'h9 : 4'hA;
            4'h9: return t ? 4'hD : 4'hB;
            4'hB: return t ? 4'h8 : 4'hB;
            4'h8: return t ? 4'hD : 4'hA;
            default: return t ? 4'h7 : 4'hC;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one tck cycle: drive, rising edge + model, falling edge + model, compare
    task automatic tick(input logic t, input logic d);
        tms = t;
        tdi = d;
        @(posedge tck);
        if (!rst_n) begin
            m_state = 4'hF; m_sr = 3'b001; m_byp = 1'b0;
        end else begin
            if (m_state == 4'hE) m_sr = 3'b001;
            else if (m_state == 4'hA) m_sr = {d, m_sr[2:1]};
            if (m_state == 4'h6 && m_ir == 3'b011) m_byp = 1'b0;
            else if (m_state == 4'h2 && m_ir == 3'b011) m_byp = d;
            m_state = nxt(m_state, t);
        end
        #2;
        check(rst_n ? "R1 state" : "R2 reset state", {4'h0, tap_state}, {4'h0, m_state});
        @(negedge tck);
        if (!rst_n) begin
            m_ir = 3'b011; m_tdo = 1'b0; m_en = 1'b0;
        end else begin
            m_en  = (m_state == 4'hA || m_state == 4'h2);
            m_tdo = (m_state == 4'hA) ? m_sr[0] :
                    (m_state == 4'h2 && m_ir == 3'b011) ? m_byp : 1'b0;
            if (m_state == 4'hF) m_ir = 3'b011;
            else if (m_state == 4'hD) m_ir = m_sr;
        end
        #2;
        check("R7 ir_value", {5'h0, ir_value}, {5'h0, m_ir});
        check("R8 tdo_en", {7'h0, tdo_en}, {7'h0, m_en});
        check(m_state == 4'hA ? "R6 tdo" : (m_state == 4'h2 ? "R9 tdo" : "R8 tdo"),
              {7'h0, tdo}, {7'h0, m_tdo});
        check("R10 strobes", {5'h0, dr_capture, dr_shift, dr_update},
              {5'h0, m_state == 4'h6, m_state == 4'h2, m_state == 4'h5});
        check("R9 bypass_sel", {7'h0, bypass_sel}, {7'h0, m_ir == 3'b011});
    endtask

    // load an instruction starting from idle and confirm the captured pattern leaves LSB first
    task automatic load_ir(input logic [2:0] v);
        logic [2:0] seen;
        tick(1, 0); tick(1, 0); tick(0, 0);
        tick(0, 0); seen[0] = tdo;
        tick(0, v[0]); seen[1] = tdo;
        tick(0, v[1]); seen[2] = tdo;
        tick(1, v[2]);
        check("R5 R6 captured pattern out", {5'h0, seen}, 8'h01);
        tick(1, 0);
        check("R7 instruction after update", {5'h0, ir_value}, {5'h0, v});
        tick(0, 0);
    endtask

    // data scan of n bits from idle; with bypass the output lags the input by one shift
    task automatic dr_scan(input int n, input logic byp);
        logic prev;
        tick(1, 0); tick(0, 0);
        tick(0, 0);
        check("R9 captured bypass bit", {7'h0, tdo}, 8'h00);
        prev = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic b;
            b = 1'($urandom);
            tick(i == n - 1, b);
            if (i < n - 1)
                check("R9 bypass lag", {7'h0, tdo}, {7'h0, byp ? b : 1'b0});
            prev = b;
        end
        tick(1, 0); tick(0, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        #1;
        tick(1, 0); tick(0, 1);
        check("R2 reset ir_value", {5'h0, ir_value}, 8'h03);
        rst_n = 1'b1;
        tick(1, 0);
        check("R2 reset state held", {4'h0, tap_state}, 8'h0F);

        // R4: spurious low then three highs
        tick(0, 0);
        check("R4 spurious low to idle", {4'h0, tap_state}, 8'h0C);
        tick(1, 0); tick(1, 0);
        check("R4 not yet reset after two", {4'h0, tap_state}, 8'h04);
        tick(1, 0);
        check("R4 back to reset", {4'h0, tap_state}, 8'h0F);
        tick(0, 0);

        // instruction scans and data scans
        load_ir(3'b101);
        dr_scan(6, 1'b0);
        load_ir(3'b011);
        dr_scan(8, 1'b1);
        load_ir(3'b110);

        // R3: random walks followed by five highs
        for (int k = 0; k < 60; k++) begin
            int len;
            len = 1 + int'($urandom % 12);
            for (int j = 0; j < len; j++) tick(1'($urandom), 1'($urandom));
            for (int j = 0; j < 5; j++) tick(1, 1'($urandom));
            check("R3 five highs reach reset", {4'h0, tap_state}, 8'h0F);
            tick(1, 0);
            check("R3 reset holds", {4'h0, tap_state}, 8'h0F);
        end

        // random streams, tms biased low so scans run long
        for (int k = 0; k < 3000; k++) begin
            tick(($urandom % 4) == 0, 1'($urandom));
        end

        // reset mid-scan
        tick(1, 0); tick(0, 0); tick(0, 0);
        rst_n = 1'b0;
        tick(0, 0);
        check("R2 reset from shift", {4'h0, tap_state}, 8'h0F);
        rst_n = 1'b1;
        tick(1, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule